// File: doc/BRIEF.md
# GPIO Pin Edge/Level Interrupt Detector

This block watches the input pins of one 16-pin general-purpose port and turns pin activity into interrupt requests. Each pin passes through a multi-flop synchronizer. A trigger stage then compares the settled sample with the sample from the cycle before, or looks at the level itself. A per-pin mode bit picks edge or level meaning. Two independent polarity enables per pin pick which edges or levels count. Qualifying events set sticky per-pin status flags. The OR of those flags forms a single interrupt request. A wake-up request pulses whenever any armed pin produces an event.

Software reaches three word registers over a simple register bus with byte-lane strobes. Reads are combinational.

- Word 0 holds the trigger enables. Bits [15:0] are the falling-edge/low-level enables and bits [31:16] are the rising-edge/high-level enables. Pin n uses bits n and n+16.
- Word 1 holds the mode bits, one per pin: 1 means level and 0 means edge.
- Word 2 holds the status flags. Writing 1 to a flag clears it.

A parameter mask marks which pins are bonded out. Masked-off pins keep no configuration, read back as zero and can never signal.

Top module: `gpio_irq_detect`

## Requirements
- R1: The enable register (word 0) holds the falling/low enable of pin n at bit n and the rising/high enable of pin n at bit n+16. It resets to all zeros and reads back what was written, for implemented pins.
- R2: After reset, with no register written, no pin activity sets a status flag, raises `irq_o` or raises `wake_o`.
- R3: The mode register (word 1, bit n for pin n) resets to zero and reads back what was written. A value of 1 selects level trigger and 0 selects edge trigger.
- R4: In level mode, a pin sets its status flag in every cycle that its synchronized value is high with the rising/high enable set, or low with the falling/low enable set.
- R5: In edge mode, a low-to-high pin change sets the flag if the rising enable is set. A high-to-low change sets it if the falling enable is set. With both enables set, both edges set it. A pin change made before clock edge k sets the flag at clock edge k+2, after two synchronizer flops.
- R6: `wake_o` is high for the cycle after each cycle in which any enabled pin produces a qualifying event. An isolated edge therefore gives a one-cycle pulse, at the same edge the flag sets.
- R7: Pins whose bit in `PIN_MASK` is 0 read as zero in all three registers. Their enables and mode bits have no effect, and they never set a flag or raise `wake_o`.
- R8: Status flags (word 2, bit n for pin n) are sticky. Writing 1 clears a flag; writing 0 leaves it unchanged.
- R9: `irq_o` is high exactly when at least one status flag is set.
- R10: If a pin event and a software clear hit the same flag in the same cycle, the flag stays set.
- R11: A register write changes only the bytes whose strobe `bus_be_i[k]` is set, covering bits [8k+7:8k]. Clearing status flags obeys the strobes too.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 16 | Asynchronous pin inputs |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word index: 0 enables, 1 mode, 2 status |
| bus_wdata_i | input | 32 | Write data |
| bus_be_i | input | 4 | Byte-lane write strobes |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the access |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Wake-up request pulse |

## Verification
The hardest case to reach is a software clear landing in the same cycle as a hardware set of the same flag. An edge event lasts only one cycle, two cycles after the pin moves, so random timing seldom lines the two up. The stimulus gets there with level mode instead: a held qualifying level sets the flag in every cycle, so any clear write collides with a set. The flag is then read back and must still be set. Random configurations with random pin steps then cover every combination of mode and polarity on every pin. Those results are compared against a bench model of the edge and level rules.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int unsigned BUS_DATA_W = 32;
   localparam int unsigned BUS_ADDR_W = 2;
   localparam logic [BUS_ADDR_W-1:0] WORD_ENABLE = 2'd0;
   localparam logic [BUS_ADDR_W-1:0] WORD_MODE   = 2'd1;
   localparam logic [BUS_ADDR_W-1:0] WORD_STATUS = 2'd2;

   typedef struct packed {
      logic rise_en;
      logic fall_en;
      logic level;
   } pin_cfg_t;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_irq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   genvar s;
   for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig
   import gpio_irq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sample_i,
   input  pin_cfg_t cfg_i,
   output logic     event_o
);
   logic prev_q;
   logic rise_seen;
   logic fall_seen;
   logic edge_hit;
   logic level_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sample_i;
   end

   always_comb begin
      rise_seen = sample_i & ~prev_q;
      fall_seen = ~sample_i & prev_q;
      edge_hit  = (rise_seen & cfg_i.rise_en) | (fall_seen & cfg_i.fall_en);
      level_hit = (sample_i & cfg_i.rise_en) | (~sample_i & cfg_i.fall_en);
      event_o   = cfg_i.level ? level_hit : edge_hit;
   end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned          NPINS    = 16,
   parameter logic [NPINS-1:0]     PIN_MASK = '1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sel_i,
   input  logic                  wr_i,
   input  logic [BUS_ADDR_W-1:0] addr_i,
   input  logic [BUS_DATA_W-1:0] wdata_i,
   input  logic [BUS_DATA_W/8-1:0] be_i,
   output logic [BUS_DATA_W-1:0] rdata_o,
   input  logic [NPINS-1:0]      event_i,
   output logic [NPINS-1:0]      rise_en_o,
   output logic [NPINS-1:0]      fall_en_o,
   output logic [NPINS-1:0]      level_o,
   output logic [NPINS-1:0]      status_o,
   output logic [NPINS-1:0]      clear_o
);
   localparam int unsigned BE_W  = BUS_DATA_W / 8;
   localparam int unsigned EN_W  = 2 * NPINS;
   localparam logic [EN_W-1:0] EN_MASK = {PIN_MASK, PIN_MASK};

   logic [BUS_DATA_W-1:0] lane_mask;
   logic [EN_W-1:0]       en_q;
   logic [NPINS-1:0]      mode_q;
   logic [NPINS-1:0]      stat_q;
   logic                  wr_en;
   logic                  wr_mode;
   logic                  wr_stat;

   genvar b;
   for (b = 0; b < BE_W; b++) begin : g_lane
      assign lane_mask[8*b +: 8] = {8{be_i[b]}};
   end

   assign wr_en   = sel_i & wr_i & (addr_i == WORD_ENABLE);
   assign wr_mode = sel_i & wr_i & (addr_i == WORD_MODE);
   assign wr_stat = sel_i & wr_i & (addr_i == WORD_STATUS);

   assign clear_o = wr_stat ? (wdata_i[NPINS-1:0] & lane_mask[NPINS-1:0]) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr_en) begin
         en_q <= ((en_q & ~lane_mask[EN_W-1:0]) |
                  (wdata_i[EN_W-1:0] & lane_mask[EN_W-1:0])) & EN_MASK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (wr_mode) begin
         mode_q <= ((mode_q & ~lane_mask[NPINS-1:0]) |
                    (wdata_i[NPINS-1:0] & lane_mask[NPINS-1:0])) & PIN_MASK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= ((stat_q & ~clear_o) | event_i) & PIN_MASK;
   end

   always_comb begin
      rdata_o = '0;
      if (sel_i && !wr_i) begin
         unique case (addr_i)
            WORD_ENABLE: rdata_o[EN_W-1:0]  = en_q;
            WORD_MODE:   rdata_o[NPINS-1:0] = mode_q;
            WORD_STATUS: rdata_o[NPINS-1:0] = stat_q;
            default:     rdata_o = '0;
         endcase
      end
   end

   assign fall_en_o = en_q[NPINS-1:0];
   assign rise_en_o = en_q[EN_W-1:NPINS];
   assign level_o   = mode_q;
   assign status_o  = stat_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gpio_irq_pkg::*;
#(
   parameter int unsigned      NPINS       = 16,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter logic [NPINS-1:0] PIN_MASK    = 16'hF0F3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] pin_i,
   input  logic        bus_sel_i,
   input  logic        bus_wr_i,
   input  logic [1:0]  bus_addr_i,
   input  logic [31:0] bus_wdata_i,
   input  logic [3:0]  bus_be_i,
   output logic [31:0] bus_rdata_o,
   output logic        irq_o,
   output logic        wake_o
);
   if (NPINS != 16) begin : g_bad_npins
      $error("gpio_irq_detect: port width is fixed at 16 pins");
   end
   if (2 * NPINS > BUS_DATA_W) begin : g_bad_bus
      $error("gpio_irq_detect: enable register does not fit the bus");
   end

   logic [NPINS-1:0] sample_w;
   logic [NPINS-1:0] event_w;
   logic [NPINS-1:0] rise_en_w;
   logic [NPINS-1:0] fall_en_w;
   logic [NPINS-1:0] level_w;
   logic [NPINS-1:0] status_w;
   logic [NPINS-1:0] clear_w;
   logic             wake_q;

   gpio_irq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (sample_w)
   );

   gpio_irq_regs #(.NPINS(NPINS), .PIN_MASK(PIN_MASK)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_i     (bus_sel_i),
      .wr_i      (bus_wr_i),
      .addr_i    (bus_addr_i),
      .wdata_i   (bus_wdata_i),
      .be_i      (bus_be_i),
      .rdata_o   (bus_rdata_o),
      .event_i   (event_w),
      .rise_en_o (rise_en_w),
      .fall_en_o (fall_en_w),
      .level_o   (level_w),
      .status_o  (status_w),
      .clear_o   (clear_w)
   );

   genvar p;
   for (p = 0; p < NPINS; p++) begin : g_pin
      if (PIN_MASK[p]) begin : g_live
         pin_cfg_t cfg;
         assign cfg.rise_en = rise_en_w[p];
         assign cfg.fall_en = fall_en_w[p];
         assign cfg.level   = level_w[p];
         gpio_irq_trig u_trig (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample_i (sample_w[p]),
            .cfg_i    (cfg),
            .event_o  (event_w[p])
         );
      end else begin : g_absent
         assign event_w[p] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_q <= 1'b0;
      else        wake_q <= |event_w;
   end

   assign irq_o  = |status_w;
   assign wake_o = wake_q;
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker #(
   parameter int unsigned      NPINS    = 16,
   parameter logic [NPINS-1:0] PIN_MASK = '1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPINS-1:0] event_w,
   input logic [NPINS-1:0] status_w,
   input logic [NPINS-1:0] clear_w,
   input logic [NPINS-1:0] rise_en_w,
   input logic [NPINS-1:0] fall_en_w,
   input logic             irq_o,
   input logic             wake_o
);
   logic [NPINS-1:0] keep_w;
   assign keep_w = status_w & ~clear_w;

   // R7: absent pins never hold a flag
   p_absent_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (status_w & ~PIN_MASK) == '0);

   // R2: with nothing enabled and nothing flagged, nothing appears
   p_idle_stays_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((rise_en_w | fall_en_w) == '0 && status_w == '0) |=> (status_w == '0 && !wake_o));

   // R8: flags not cleared stay set
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_w & $past(keep_w)) == $past(keep_w)));

   // R10: a pin event always leaves its flag set, even against a clear
   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_w & $past(event_w)) == $past(event_w)));

   // R6: a wake pulse comes with a raised interrupt
   p_wake_with_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> irq_o);

   // R9: clearing every flag with no new event drops the request
   p_irq_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (keep_w == '0 && event_w == '0) |=> !irq_o);
endmodule

bind gpio_irq_detect gpio_irq_checker #(.NPINS(NPINS), .PIN_MASK(PIN_MASK)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .event_w   (event_w),
   .status_w  (status_w),
   .clear_w   (clear_w),
   .rise_en_w (rise_en_w),
   .fall_en_w (fall_en_w),
   .irq_o     (irq_o),
   .wake_o    (wake_o)
);

// File: tb/sim_gpio_irq_detect.sv
`timescale 1ns/1ps
module sim_gpio_irq_detect;
   localparam logic [15:0] MASK = 16'hF0F3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pin_i = '0;
   logic        bus_sel_i = 1'b0;
   logic        bus_wr_i = 1'b0;
   logic [1:0]  bus_addr_i = '0;
   logic [31:0] bus_wdata_i = '0;
   logic [3:0]  bus_be_i = '0;
   logic [31:0] bus_rdata_o;
   logic        irq_o;
   logic        wake_o;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   gpio_irq_detect #(.PIN_MASK(MASK)) u0 (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d; bus_be_i = be;
      @(posedge clk);
      @(negedge clk);
      bus_sel_i = 1'b0; bus_wr_i = 1'b0; bus_be_i = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a;
      #1 d = bus_rdata_o;
      bus_sel_i = 1'b0;
   endtask

   function automatic logic [15:0] lvl_bits(input logic [15:0] p, input logic [31:0] en, input logic [15:0] ty);
      return MASK & ty & ((p & en[31:16]) | (~p & en[15:0]));
   endfunction

   function automatic logic [15:0] edge_bits(input logic [15:0] o, input logic [15:0] n,
                                             input logic [31:0] en, input logic [15:0] ty);
      return MASK & ~ty & ((n & ~o & en[31:16]) | (~n & o & en[15:0]));
   endfunction

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [31:0] en;
      logic [15:0] ty;
      logic [15:0] exp;
      logic [15:0] np;
      void'($urandom(32'd20240611));
      cycles(3);
      rst_n = 1'b1;
      cycles(2);

      // R1 R3 reset values
      rd(2'd0, d); check("R1 enable reset", d, 32'h0);
      rd(2'd1, d); check("R3 mode reset", d, 32'h0);
      check("R2 irq after reset", {31'b0, irq_o}, 32'h0);

      // R2 activity with nothing enabled
      pin_i = 16'hFFFF; cycles(6); pin_i = 16'h0000; cycles(6);
      rd(2'd2, d); check("R2 status quiet", d, 32'h0);
      check("R2 wake quiet", {31'b0, wake_o}, 32'h0);

      // R11 byte strobes, R7 masked readback
      wr(2'd0, 32'hFFFF_FFFF, 4'b0010);
      rd(2'd0, d); check("R11 enable lane 1 only", d, 32'h0000_F000);
      wr(2'd0, 32'hFFFF_FFFF, 4'b1111);
      rd(2'd0, d); check("R7 R1 enable readback masked", d, {MASK, MASK});
      wr(2'd1, 32'hFFFF_FFFF, 4'b1111);
      rd(2'd1, d); check("R7 R3 mode readback masked", d, {16'h0, MASK});
      wr(2'd1, 32'h0, 4'b1111);
      wr(2'd0, 32'h0001_0000, 4'b1111);
      rd(2'd0, d); check("R1 rise enable of pin 0 at bit 16", d, 32'h0001_0000);
      wr(2'd2, 32'hFFFF, 4'b0011);

      // R5 R6 latency of a rising edge on pin 0
      @(negedge clk); pin_i[0] = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      check("R5 no flag before edge k+2", {31'b0, irq_o}, 32'h0);
      @(posedge clk); #1;
      check("R6 wake pulse at edge k+2", {31'b0, wake_o}, 32'h1);
      check("R9 irq follows flag", {31'b0, irq_o}, 32'h1);
      @(posedge clk); #1;
      check("R6 wake pulse is one cycle", {31'b0, wake_o}, 32'h0);
      // falling edge not enabled
      pin_i[0] = 1'b0;
      cycles(6);
      wr(2'd2, 32'h0, 4'b1111);
      rd(2'd2, d); check("R8 writing zero keeps flag", d, 32'h1);
      wr(2'd2, 32'h1, 4'b0010);
      rd(2'd2, d); check("R11 clear blocked by strobe", d, 32'h1);
      wr(2'd2, 32'h1, 4'b0001);
      rd(2'd2, d); check("R8 write one clears flag", d, 32'h0);
      check("R9 irq low after clear", {31'b0, irq_o}, 32'h0);

      // R7 absent pin 2 in level mode does nothing
      wr(2'd0, 32'hFFFF_FFFF, 4'b1111);
      wr(2'd1, 32'h0000_0004, 4'b1111);
      wr(2'd2, 32'hFFFF, 4'b1111);
      pin_i[2] = 1'b1; cycles(6); pin_i[2] = 1'b0; cycles(6);
      rd(2'd2, d); check("R7 absent pin gives no flag", d, 32'h0);
      check("R7 absent pin gives no wake", {31'b0, wake_o}, 32'h0);

      // R4 R10 held high level on pin 4; clear collides with set
      wr(2'd0, 32'h0010_0000, 4'b1111);
      wr(2'd1, 32'h0000_0010, 4'b1111);
      pin_i[4] = 1'b1; cycles(6);
      rd(2'd2, d); check("R4 high level sets flag", d, 32'h10);
      wr(2'd2, 32'h10, 4'b1111);
      rd(2'd2, d); check("R10 set wins over clear", d, 32'h10);
      check("R4 wake held during level", {31'b0, wake_o}, 32'h1);
      pin_i[4] = 1'b0; cycles(6);
      wr(2'd2, 32'h10, 4'b1111);
      rd(2'd2, d); check("R4 flag clears once level gone", d, 32'h0);

      // random configurations and pin steps: R4 R5 R9
      for (int it = 0; it < 40; it++) begin
         en = $urandom();
         ty = 16'($urandom());
         if (it % 4 == 0) en = 32'hFFFF_FFFF;
         wr(2'd0, en, 4'b1111);
         wr(2'd1, {16'h0, ty}, 4'b1111);
         cycles(4);
         wr(2'd2, 32'hFFFF, 4'b1111);
         cycles(4);
         exp = lvl_bits(pin_i, en, ty);
         for (int st = 0; st < 6; st++) begin
            np = 16'($urandom());
            exp = exp | edge_bits(pin_i, np, en, ty) | lvl_bits(np, en, ty);
            pin_i = np;
            cycles(6);
            rd(2'd2, d);
            check("R4 R5 random status", d, {16'h0, exp});
            check("R9 random irq", {31'b0, irq_o}, {31'b0, |exp});
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule